// File: doc/BRIEF.md
# Two-Phase Shared Parallel Bus with Response Watchdog

This block models a clocked parallel bus inside one clock domain. A single master port takes commands from the surrounding logic and places them on shared bus lines. Several memory-backed targets each own a fixed window of the address space. A watchdog in the bus fabric ends any transaction that no target answers. Bus time alternates between two kinds of clock edge. On a launch edge, drivers may change the bus lines. On the following capture edge, receivers may read them. This keeps every driven value stable for a full clock period before anyone samples it.

A command carries an operation (single read, single write or burst read), an address, write data and a burst length, all accepted together. The target whose window contains the address carries out the operation. It raises its completion line once per beat and returns read data with it. A burst walks upward through the target's window and wraps inside that window. When no target answers for a parameterised number of capture edges, the watchdog raises an error line for one bus cycle. The master then reports a failed, final response and frees the bus.

Top module: `bpbus_top`

## Requirements
- R1: Bus request, address, data, completion and error lines change only on launch edges. The first edge after reset is a launch edge, and launch and capture edges then alternate. `cmd_ready` is high only in the cycles before a launch edge. Responses are captured only on capture edges.
- R2: A single read (`cmd_op`=01) accepted at edge n returns the stored word with `rsp_err`=0 and `rsp_last`=1 in the one cycle after edge n+3. `cmd_len` is ignored.
- R3: A single write (`cmd_op`=10) stores `cmd_wdata` at the target address and yields exactly one response with `rsp_err`=0, `rsp_last`=1 and data 0. `cmd_len` is ignored.
- R4: Target i (0 to NSLV-1) owns addresses i*DEPTH to i*DEPTH+DEPTH-1. Only the owning target answers, and at most one completion line is active at a time.
- R5: A burst read (`cmd_op`=11) returns `cmd_len`+1 beats, one every two clocks. Beat k comes from offset (start offset + k) mod DEPTH within the same target. Only the final beat has `rsp_last`=1.
- R6: An address that no target owns, accepted at edge n, gets one response after edge n+2*TIMEOUT+1 with `rsp_err`=1, `rsp_last`=1 and data 0. This holds for bursts too.
- R7: A command with `cmd_op`=00 is not taken. It produces no response and leaves target storage unchanged.
- R8: `rsp_valid` is a one-cycle pulse. After a single-beat transaction accepted at edge n, `cmd_ready` is low until after edge n+5, when the next command may be taken.
- R9: The error line lasts exactly one bus cycle. The next transaction after an error response completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master idle and the next edge is a launch edge |
| cmd_op | input | 2 | 00 none, 01 read, 10 write, 11 burst read |
| cmd_addr | input | AW | Target address |
| cmd_wdata | input | DW | Write data |
| cmd_len | input | LW | Burst beats minus one |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Transaction ended by the watchdog |
| rsp_last | output | 1 | Final response of the transaction |

## Verification
The hardest case to reach is the watchdog expiring on a burst command. The bus must then end with a single error response rather than one per expected beat. Nothing must happen before exactly 2*TIMEOUT+1 edges, and the next command must still work. The stimulus table sends burst and single commands to unowned addresses, with normal reads right after them. A burst that starts two words below a window's end, and one that covers a whole window, exercise the wrap inside a target. The exact edge of every beat is checked against the two-phase timing.

// File: rtl/bpbus_pkg.sv
package bpbus_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_BLK = 2'b11
  } bus_op_e;
endpackage

// File: rtl/bpbus_master.sv
module bpbus_master
  import bpbus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          asrt,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [LW-1:0] cmd_len,
  output logic          b_req,
  output bus_op_e       b_op,
  output logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_wdata,
  output logic [LW-1:0] b_len,
  input  logic          b_done,
  input  logic          b_err,
  input  logic [DW-1:0] b_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          rsp_last
);
  typedef enum logic [1:0] {M_IDLE, M_WAIT, M_REL} mst_e;
  mst_e          st;
  logic [LW-1:0] beat;
  logic          fin;

  assign cmd_ready = (st == M_IDLE) && asrt;
  assign fin       = (b_op != OP_BLK) || (beat == b_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= M_IDLE; b_req <= 1'b0; b_op <= OP_NOP;
      b_addr <= '0; b_wdata <= '0; b_len <= '0; beat <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0; rsp_err <= 1'b0; rsp_last <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_last  <= 1'b0;
      if (asrt) begin
        if (st == M_IDLE && cmd_valid && cmd_op != 2'b00) begin
          b_req   <= 1'b1;
          b_op    <= bus_op_e'(cmd_op);
          b_addr  <= cmd_addr;
          b_wdata <= cmd_wdata;
          b_len   <= cmd_len;
          beat    <= '0;
          st      <= M_WAIT;
        end else if (st == M_REL) begin
          b_req <= 1'b0;
          b_op  <= OP_NOP;
          st    <= M_IDLE;
        end
      end else if (st == M_WAIT) begin
        if (b_err) begin
          rsp_valid <= 1'b1; rsp_err <= 1'b1; rsp_last <= 1'b1;
          rsp_data  <= '0;
          st        <= M_REL;
        end else if (b_done) begin
          rsp_valid <= 1'b1;
          rsp_data  <= (b_op == OP_WR) ? '0 : b_rdata;
          rsp_last  <= fin;
          if (fin) st <= M_REL;
          else     beat <= beat + 1'b1;
        end
      end
    end
  end

  p_bus_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !asrt |=> $stable({b_req, b_op, b_addr, b_wdata, b_len}));
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  p_err_last_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_last));
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (st == M_REL && asrt) |=> !b_req);
endmodule

// File: rtl/bpbus_slave.sv
module bpbus_slave
  import bpbus_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LW    = 4,
  parameter int DEPTH = 16,
  parameter int BASE  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          asrt,
  input  logic          b_req,
  input  bus_op_e       b_op,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  input  logic [LW-1:0] b_len,
  output logic          s_done,
  output logic [DW-1:0] s_rdata
);
  localparam int OFFW = $clog2(DEPTH);
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} slv_e;
  slv_e            st;
  logic [OFFW-1:0] ptr;
  logic [LW-1:0]   left;
  logic            hit, start;
  logic [AW-1:0]   rel;
  logic [DW-1:0]   mem [DEPTH];

  assign hit   = ({1'b0, b_addr} >= LO) && ({1'b0, b_addr} < HI);
  assign rel   = b_addr - AW'(BASE);
  assign start = !asrt && (st == S_IDLE) && b_req && hit && (b_op != OP_NOP);

  always_ff @(posedge clk) begin
    if (!rst && start && b_op == OP_WR) mem[rel[OFFW-1:0]] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (asrt && st == S_RUN) s_rdata <= mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ptr <= '0; left <= '0; s_done <= 1'b0;
    end else if (asrt) begin
      if (st == S_RUN) begin
        s_done <= 1'b1;
        ptr    <= ptr + 1'b1;
        if (left == '0) st <= S_HOLD;
        else            left <= left - 1'b1;
      end else begin
        s_done <= 1'b0;
      end
    end else begin
      if (start) begin
        st   <= S_RUN;
        ptr  <= rel[OFFW-1:0];
        left <= (b_op == OP_BLK) ? b_len : '0;
      end else if (st == S_HOLD && !b_req) begin
        st <= S_IDLE;
      end
    end
  end

  p_done_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !asrt |=> $stable(s_done));
  p_miss_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !asrt && !hit) |=> (st == S_IDLE));
endmodule

// File: rtl/bpbus_monitor.sv
module bpbus_monitor #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic asrt,
  input  logic b_req,
  input  logic b_done,
  output logic b_err
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LIM = TW'(TIMEOUT);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; b_err <= 1'b0;
    end else if (asrt) begin
      if (b_err) begin
        b_err <= 1'b0;
      end else if (cnt == LIM) begin
        b_err <= 1'b1;
        cnt   <= '0;
      end
    end else begin
      if (!b_req || b_done) cnt <= '0;
      else if (cnt != LIM)  cnt <= cnt + 1'b1;
    end
  end

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (b_err && asrt) |=> !b_err);
  p_err_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !asrt |=> $stable(b_err));
  p_err_nodone_r6: assert property (@(posedge clk) disable iff (rst)
    b_err |-> !b_done);
endmodule

// File: rtl/bpbus_top.sv
module bpbus_top
  import bpbus_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int LW      = 4,
  parameter int NSLV    = 3,
  parameter int DEPTH   = 16,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [LW-1:0] cmd_len,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          rsp_last
);
  logic          ph, asrt;
  logic          b_req, b_done, b_err;
  bus_op_e       b_op;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_wdata, b_rdata;
  logic [LW-1:0] b_len;
  logic [NSLV-1:0] done_vec;
  logic [DW-1:0] rdata_arr [NSLV];

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end
  assign asrt = ~ph;

  bpbus_master #(.AW(AW), .DW(DW), .LW(LW)) u_mst (
    .clk, .rst, .asrt, .cmd_valid, .cmd_ready, .cmd_op, .cmd_addr,
    .cmd_wdata, .cmd_len, .b_req, .b_op, .b_addr, .b_wdata, .b_len,
    .b_done, .b_err, .b_rdata, .rsp_valid, .rsp_data, .rsp_err, .rsp_last
  );

  for (genvar i = 0; i < NSLV; i++) begin : g_slv
    bpbus_slave #(.AW(AW), .DW(DW), .LW(LW), .DEPTH(DEPTH), .BASE(i * DEPTH)) u_slv (
      .clk, .rst, .asrt, .b_req, .b_op, .b_addr, .b_wdata, .b_len,
      .s_done(done_vec[i]), .s_rdata(rdata_arr[i])
    );
  end

  always_comb begin
    b_rdata = '0;
    for (int i = 0; i < NSLV; i++)
      if (done_vec[i]) b_rdata = b_rdata | rdata_arr[i];
  end
  assign b_done = |done_vec;

  bpbus_monitor #(.TIMEOUT(TIMEOUT)) u_mon (
    .clk, .rst, .asrt, .b_req, .b_done, .b_err
  );

  p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_vec));
  p_req_done_r4: assert property (@(posedge clk) disable iff (rst)
    b_done |-> b_req);
endmodule

// File: tb/bpbus_top_tb_top.sv
module bpbus_top_tb_top;
  localparam int T = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [3:0] cmd_len = '0;
  logic rsp_valid, rsp_err, rsp_last;
  logic [15:0] rsp_data;

  int tests = 0, fails = 0;
  int nrsp, lat0;
  logic [15:0] rdat [32];
  logic rerr [32], rlast [32];
  int rk [32];

  always #10 clk = ~clk;

  bpbus_top dut_i (
    .clk, .rst, .cmd_valid, .cmd_ready, .cmd_op, .cmd_addr, .cmd_wdata,
    .cmd_len, .rsp_valid, .rsp_data, .rsp_err, .rsp_last
  );

  // op[14:13] addr[12:5] len[4:1] err[0]
  localparam logic [14:0] VEC [10] = '{
    {2'b01, 8'h00, 4'h7, 1'b0},
    {2'b01, 8'h1F, 4'h0, 1'b0},
    {2'b01, 8'h2A, 4'h3, 1'b0},
    {2'b11, 8'h04, 4'h3, 1'b0},
    {2'b11, 8'h1E, 4'h3, 1'b0},
    {2'b11, 8'h20, 4'hF, 1'b0},
    {2'b11, 8'h2F, 4'h0, 1'b0},
    {2'b01, 8'h30, 4'h0, 1'b1},
    {2'b11, 8'h45, 4'h2, 1'b1},
    {2'b01, 8'hFF, 4'h0, 1'b1}
  };

  function automatic logic [15:0] patt(input logic [7:0] a);
    return {a, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [3:0] len, input logic [15:0] wd);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_len = len; cmd_wdata = wd; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic collect(input int maxk);
    nrsp = 0; lat0 = -1;
    for (int k = 1; k <= maxk; k++) begin
      @(negedge clk);
      if (rsp_valid && nrsp < 32) begin
        rdat[nrsp] = rsp_data; rerr[nrsp] = rsp_err; rlast[nrsp] = rsp_last; rk[nrsp] = k;
        if (nrsp == 0) lat0 = k;
        nrsp++;
        if (rsp_last) break;
      end
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] ea;
    int beats;
    bit rdy_lo, rdy_hi, seen;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && !rsp_err && !rsp_last, "R8 reset outputs", {rsp_valid, rsp_err, rsp_last}, 0);
    chk(cmd_ready, "R1 ready before first launch edge", cmd_ready, 1);
    @(negedge clk);
    chk(!cmd_ready, "R1 ready low before capture edge", cmd_ready, 0);

    // R3: fill all targets, len field nonzero and ignored
    for (int a = 0; a < 48; a++) begin
      issue(2'b10, 8'(a), 4'hA, patt(8'(a)));
      collect(60);
      chk(nrsp == 1 && !rerr[0] && rlast[0] && rdat[0] == 0, "R3 write single response", nrsp, 1);
    end

    // table walk: R2 R4 R5 R6 R9
    for (int v = 0; v < 10; v++) begin
      issue(VEC[v][14:13], VEC[v][12:5], VEC[v][4:1], 16'h0);
      collect(60);
      beats = VEC[v][0] ? 1 : (VEC[v][14:13] == 2'b11 ? int'(VEC[v][4:1]) + 1 : 1);
      chk(nrsp == beats, "R5 beat count", nrsp, beats);
      if (VEC[v][0])
        chk(lat0 == 2*T + 2, "R6 timeout latency", lat0, 2*T + 2);
      else
        chk(lat0 == 4, "R2 first response latency", lat0, 4);
      for (int b = 0; b < nrsp; b++) begin
        ea = {VEC[v][12:9], 4'(VEC[v][8:5] + 4'(b))};
        if (VEC[v][0])
          chk(rerr[b] && rlast[b] && rdat[b] == 0, "R6 error response", {rerr[b], rdat[b]}, 32'h10000);
        else
          chk(!rerr[b] && rdat[b] == patt(ea) && rlast[b] == (b == nrsp - 1), "R4 R5 beat data",
              rdat[b], patt(ea));
        if (b > 0) chk(rk[b] - rk[b-1] == 2, "R5 beat spacing", rk[b] - rk[b-1], 2);
      end
      if (VEC[v][0]) begin
        issue(2'b01, 8'h11, 4'h0, 16'h0);
        collect(60);
        chk(nrsp == 1 && !rerr[0] && rdat[0] == patt(8'h11), "R9 read after error", rdat[0], patt(8'h11));
      end
    end

    // R8: ready timing after a single read
    issue(2'b01, 8'h00, 4'h0, 16'h0);
    rdy_lo = 1'b0; rdy_hi = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 5) rdy_lo = !cmd_ready;
      if (k == 6) rdy_hi = cmd_ready;
    end
    chk(rdy_lo, "R8 ready low after edge n+4", rdy_lo, 1);
    chk(rdy_hi, "R8 ready high after edge n+5", rdy_hi, 1);

    // R7: no-op command held, nothing happens
    @(negedge clk);
    cmd_op = 2'b00; cmd_addr = 8'h05; cmd_wdata = 16'hDEAD; cmd_valid = 1'b1;
    seen = 1'b0; rdy_hi = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (rsp_valid) seen = 1'b1;
      if (cmd_ready) rdy_hi = 1'b1;
    end
    cmd_valid = 1'b0;
    chk(!seen, "R7 no response to op 00", seen, 0);
    chk(rdy_hi, "R7 master stays idle", rdy_hi, 1);
    issue(2'b01, 8'h05, 4'h0, 16'h0);
    collect(60);
    chk(nrsp == 1 && rdat[0] == patt(8'h05), "R7 storage unchanged", rdat[0], patt(8'h05));

    // R3: overwrite and read back
    issue(2'b10, 8'h13, 4'h0, 16'hBEEF);
    collect(60);
    issue(2'b01, 8'h13, 4'h0, 16'h0);
    collect(60);
    chk(nrsp == 1 && rdat[0] == 16'hBEEF, "R3 write then read", rdat[0], 16'hBEEF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule